// File: doc/BRIEF.md
# Serial Ethernet Receive Deframer with Byte-Boundary CRC Check

This block sits behind a serial receive interface that presents one NRZ bit per strobe together with a carrier-sense level. While carrier is up it searches the alternating preamble for the start-of-frame mark. The mark is two consecutive one bits. Every bit after the mark is packed into bytes, least significant bit first. Each byte is pushed out as a single-cycle pulse on a byte stream, and the frame check sequence bytes are included in that stream.

A bit-serial CRC-32 register is restarted at every start-of-frame mark and advances on every data bit. Each time a byte completes, the register is compared with the CRC-32 residue constant. When carrier falls, the result of the comparison at the last byte boundary decides the verdict. A match gives a good frame. A mismatch gives a CRC error. If the mismatch comes with leftover bits that do not fill a whole byte, an alignment error is also flagged. Leftover bits are dropped. A discard input lets downstream address filtering reject the frame in progress. The block returns to hunting as soon as carrier falls, so a new frame may begin on the very next cycle.

Top module: `eth_rx_deframer`

## Requirements
- R1: After reset, byte_valid, frame_end and all four status flags are 0.
- R2: While carrier is high and no frame is open, qualified bits are discarded until two consecutive qualified ones arrive. The next qualified bit is the first data bit. If carrier drops before that pair arrives, no frame_end is produced.
- R3: Data bits are packed least significant bit first, so the first bit after the mark lands in byte_data bit 0. byte_valid is high for one cycle, starting the cycle after the strobe of a byte's eighth bit. Every complete byte is output, including the four check-sequence bytes. An incomplete final byte is never output.
- R4: The CRC register is restarted at each start-of-frame mark, so each frame's verdict is independent of the frames before it.
- R5: frame_end pulses for exactly one cycle, the cycle after carrier is first sampled low inside a frame. If the register equalled the residue 0xDEBB20E3 at the last byte boundary, stat_good=1, stat_crc_err=0 and stat_align_err=0. This holds even when 1 to 7 extra bits followed that boundary.
- R6: If the last byte-boundary comparison failed and carrier dropped on a byte boundary, then stat_crc_err=1, stat_align_err=0 and stat_good=0. A frame that ends with no complete byte counts as such a failure.
- R7: If the last byte-boundary comparison failed and carrier dropped with 1 to 7 leftover bits, then stat_align_err=1 and stat_crc_err=1. stat_align_err is never 1 while stat_crc_err is 0.
- R8: If discard is high in any cycle of an open frame, byte_valid stays low for the rest of that frame. At frame_end, stat_discarded=1 and stat_good=0, and the CRC flags are still reported. The condition clears at the next start-of-frame mark.
- R9: The status flags change only in the cycle frame_end is high and hold until the next frame_end. A frame whose carrier rises in the cycle after the previous carrier drop is received normally.
- R10: Bits presented while rx_valid is low have no effect on hunting, packing or the CRC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier | input | 1 | Carrier sense level; its fall ends a frame |
| rx_valid | input | 1 | Strobe qualifying rx_bit for one cycle |
| rx_bit | input | 1 | Serial NRZ receive bit |
| discard | input | 1 | Reject the frame in progress (from address filtering) |
| byte_valid | output | 1 | One-cycle pulse marking byte_data valid |
| byte_data | output | 8 | Assembled received byte |
| frame_end | output | 1 | One-cycle pulse when the status of a frame is updated |
| stat_good | output | 1 | Last frame passed the CRC check and was not discarded |
| stat_crc_err | output | 1 | Last frame failed the byte-boundary CRC check |
| stat_align_err | output | 1 | Last frame failed the CRC check and ended off a byte boundary |
| stat_discarded | output | 1 | Last frame was rejected through discard |

## Verification
Some properties are checked on every cycle. An alignment error never appears without a CRC error. A good verdict never coincides with a CRC error. frame_end never lasts two cycles. Status changes only together with frame_end. Bytes emerge only from an open frame. The consecutive-ones and bit counters stay in range, and the CRC register holds its seed right after a mark. Other behaviour only the bench scenarios can show: that the residue comparison actually separates good from corrupted frames, that bit order and byte contents are right, and that trailing bits, discard timing, preamble aborts and back-to-back frames produce the verdicts the requirements give.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;

   typedef enum logic {
      ST_HUNT = 1'b0,
      ST_DATA = 1'b1
   } rx_state_e;

   typedef struct packed {
      logic good;
      logic crc_err;
      logic align_err;
      logic discarded;
   } rx_status_t;

   localparam logic [31:0] CRC32_POLY_REFL = 32'hEDB88320;
   localparam logic [31:0] CRC32_SEED      = 32'hFFFFFFFF;
   localparam logic [31:0] CRC32_RESIDUE   = 32'hDEBB20E3;

endpackage

// File: rtl/eth_rx_sfd_hunt.sv
module eth_rx_sfd_hunt #(
   parameter int ONES_NEEDED = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic carrier,
   input  logic bit_stb,
   input  logic bit_in,
   output logic sfd_hit
);
   localparam int CW = $clog2(ONES_NEEDED + 1);
   localparam logic [CW-1:0] LAST = CW'(ONES_NEEDED - 1);

   generate
      if (ONES_NEEDED < 2) begin : g_bad_ones
         $error("eth_rx_sfd_hunt: ONES_NEEDED must be at least 2");
      end
   endgenerate

   logic [CW-1:0] ones_q;

   assign sfd_hit = enable & carrier & bit_stb & bit_in & (ones_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ones_q <= '0;
      end else if (!enable || !carrier) begin
         ones_q <= '0;
      end else if (bit_stb) begin
         if (!bit_in || sfd_hit) ones_q <= '0;
         else                    ones_q <= ones_q + 1'b1;
      end
   end

   p_ones_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ones_q < CW'(ONES_NEEDED));

   p_no_count_on_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && carrier && !bit_stb) |=> $stable(ones_q));

endmodule

// File: rtl/eth_rx_crc_serial.sv
module eth_rx_crc_serial #(
   parameter int          W         = 32,
   parameter logic [W-1:0] POLY     = eth_rx_pkg::CRC32_POLY_REFL,
   parameter logic [W-1:0] SEED     = eth_rx_pkg::CRC32_SEED,
   parameter logic [W-1:0] RESIDUE  = eth_rx_pkg::CRC32_RESIDUE,
   parameter bit           REFLECTED = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic shift_en,
   input  logic bit_in,
   output logic residue_next
);
   generate
      if (W < 8) begin : g_bad_width
         $error("eth_rx_crc_serial: W must be at least 8");
      end
   endgenerate

   logic [W-1:0] crc_q;
   logic [W-1:0] crc_next;

   generate
      if (REFLECTED) begin : g_refl
         logic fb;
         assign fb       = crc_q[0] ^ bit_in;
         assign crc_next = {1'b0, crc_q[W-1:1]} ^ (fb ? POLY : '0);
      end else begin : g_norm
         logic fb;
         assign fb       = crc_q[W-1] ^ bit_in;
         assign crc_next = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
      end
   endgenerate

   assign residue_next = (crc_next == RESIDUE);

   always_ff @(posedge clk) begin
      if (!rst_n)        crc_q <= SEED;
      else if (clear)    crc_q <= SEED;
      else if (shift_en) crc_q <= crc_next;
   end

   p_seed_after_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (crc_q == SEED));

   p_hold_without_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !shift_en) |=> $stable(crc_q));

endmodule

// File: rtl/eth_rx_byte_pack.sv
module eth_rx_byte_pack #(
   parameter int BYTE_W    = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              shift_en,
   input  logic              bit_in,
   output logic [BYTE_W-1:0] byte_next,
   output logic              last_bit,
   output logic              partial
);
   localparam int CNT_W = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

   generate
      if (BYTE_W < 2 || (BYTE_W & (BYTE_W - 1)) != 0) begin : g_bad_byte
         $error("eth_rx_byte_pack: BYTE_W must be a power of two >= 2");
      end
   endgenerate

   logic [BYTE_W-2:0] held_q;
   logic [CNT_W-1:0]  cnt_q;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign byte_next = {bit_in, held_q};
         always_ff @(posedge clk) begin
            if (shift_en) held_q <= byte_next[BYTE_W-1:1];
         end
      end else begin : g_msb
         assign byte_next = {held_q, bit_in};
         always_ff @(posedge clk) begin
            if (shift_en) held_q <= byte_next[BYTE_W-2:0];
         end
      end
   endgenerate

   assign last_bit = (cnt_q == CNT_LAST);
   assign partial  = (cnt_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt_q <= '0;
      else if (clear)    cnt_q <= '0;
      else if (shift_en) cnt_q <= cnt_q + 1'b1;
   end

   p_cnt_zero_after_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !partial);

   p_wrap_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && last_bit && !clear) |=> !partial);

endmodule

// File: rtl/eth_rx_deframer.sv
module eth_rx_deframer #(
   parameter int  BYTE_W      = 8,
   parameter int  SFD_ONES    = 2,
   parameter int  CRC_W       = 32,
   parameter logic [CRC_W-1:0] CRC_POLY    = eth_rx_pkg::CRC32_POLY_REFL,
   parameter logic [CRC_W-1:0] CRC_SEED    = eth_rx_pkg::CRC32_SEED,
   parameter logic [CRC_W-1:0] CRC_RESIDUE = eth_rx_pkg::CRC32_RESIDUE,
   parameter bit  LSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              carrier,
   input  logic              rx_valid,
   input  logic              rx_bit,
   input  logic              discard,
   output logic              byte_valid,
   output logic [BYTE_W-1:0] byte_data,
   output logic              frame_end,
   output logic              stat_good,
   output logic              stat_crc_err,
   output logic              stat_align_err,
   output logic              stat_discarded
);
   import eth_rx_pkg::*;

   generate
      if (CRC_W % BYTE_W != 0) begin : g_bad_crc_w
         $error("eth_rx_deframer: CRC_W must be a whole number of bytes");
      end
   endgenerate

   rx_state_e  state_q;
   rx_status_t status_q;
   logic       in_frame, bit_stb, data_stb, sfd_hit;
   logic       last_bit, partial, residue_next, boundary_stb;
   logic       match_q, drop_q, suppress;
   logic [BYTE_W-1:0] byte_next;
   logic       byte_valid_q, frame_end_q;
   logic [BYTE_W-1:0] byte_data_q;

   assign in_frame     = (state_q == ST_DATA);
   assign bit_stb      = rx_valid & carrier;
   assign data_stb     = in_frame & bit_stb;
   assign boundary_stb = data_stb & last_bit;
   assign suppress     = drop_q | (in_frame & discard);

   eth_rx_sfd_hunt #(.ONES_NEEDED(SFD_ONES)) u_hunt (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (!in_frame),
      .carrier (carrier),
      .bit_stb (bit_stb),
      .bit_in  (rx_bit),
      .sfd_hit (sfd_hit)
   );

   eth_rx_crc_serial #(
      .W        (CRC_W),
      .POLY     (CRC_POLY),
      .SEED     (CRC_SEED),
      .RESIDUE  (CRC_RESIDUE),
      .REFLECTED(LSB_FIRST)
   ) u_crc (
      .clk          (clk),
      .rst_n        (rst_n),
      .clear        (sfd_hit),
      .shift_en     (data_stb),
      .bit_in       (rx_bit),
      .residue_next (residue_next)
   );

   eth_rx_byte_pack #(.BYTE_W(BYTE_W), .LSB_FIRST(LSB_FIRST)) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (sfd_hit),
      .shift_en  (data_stb),
      .bit_in    (rx_bit),
      .byte_next (byte_next),
      .last_bit  (last_bit),
      .partial   (partial)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_HUNT;
         match_q      <= 1'b0;
         drop_q       <= 1'b0;
         byte_valid_q <= 1'b0;
         byte_data_q  <= '0;
         frame_end_q  <= 1'b0;
         status_q     <= '0;
      end else begin
         byte_valid_q <= boundary_stb & !suppress;
         frame_end_q  <= in_frame & !carrier;
         if (boundary_stb) byte_data_q <= byte_next;

         if (sfd_hit)           match_q <= 1'b0;
         else if (boundary_stb) match_q <= residue_next;

         if (sfd_hit)                 drop_q <= 1'b0;
         else if (in_frame & discard) drop_q <= 1'b1;

         if (in_frame && !carrier) begin
            state_q            <= ST_HUNT;
            status_q.good      <= match_q & !suppress;
            status_q.crc_err   <= !match_q;
            status_q.align_err <= !match_q & partial;
            status_q.discarded <= suppress;
         end else if (sfd_hit) begin
            state_q <= ST_DATA;
         end
      end
   end

   assign byte_valid     = byte_valid_q;
   assign byte_data      = byte_data_q;
   assign frame_end      = frame_end_q;
   assign stat_good      = status_q.good;
   assign stat_crc_err   = status_q.crc_err;
   assign stat_align_err = status_q.align_err;
   assign stat_discarded = status_q.discarded;

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (!byte_valid && !frame_end && !stat_good && !stat_crc_err));

   p_byte_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |-> $past(in_frame));

   p_end_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> !frame_end);

   p_good_excl_crc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(stat_good && stat_crc_err));

   p_align_implies_crc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stat_align_err |-> stat_crc_err);

   p_discard_not_good_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stat_discarded |-> !stat_good);

   p_status_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end |-> $stable(status_q));

endmodule

// File: tb/tb_eth_rx_deframer.sv
`timescale 1ns/1ps
module tb_eth_rx_deframer;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic carrier = 1'b0, rx_valid = 1'b0, rx_bit = 1'b0, discard = 1'b0;
   logic byte_valid, frame_end, stat_good, stat_crc_err, stat_align_err, stat_discarded;
   logic [7:0] byte_data;

   always #2.5 clk = ~clk;

   eth_rx_deframer dut (
      .clk(clk), .rst_n(rst_n), .carrier(carrier), .rx_valid(rx_valid),
      .rx_bit(rx_bit), .discard(discard), .byte_valid(byte_valid),
      .byte_data(byte_data), .frame_end(frame_end), .stat_good(stat_good),
      .stat_crc_err(stat_crc_err), .stat_align_err(stat_align_err),
      .stat_discarded(stat_discarded)
   );

   int vec = 0, bad = 0, ends = 0, rx_n = 0;
   logic [7:0] rx [0:127];
   logic [7:0] tx [0:127];
   logic done = 1'b0;

   always @(negedge clk) begin
      if (byte_valid && rx_n < 128) begin
         rx[rx_n] = byte_data;
         rx_n++;
      end
      if (frame_end) ends++;
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      vec++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] fcs_of(input int n);
      logic [31:0] c = 32'hFFFFFFFF;
      for (int i = 0; i < n; i++)
         for (int b = 0; b < 8; b++)
            c = (c >> 1) ^ ((c[0] ^ tx[i][b]) ? 32'hEDB88320 : 32'h0);
      return ~c;
   endfunction

   task automatic send_bit(input logic b);
      @(negedge clk); rx_valid = 1'b1; rx_bit = b;
      @(negedge clk); rx_valid = 1'b0; rx_bit = ~b;
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) send_bit(v[i]);
   endtask

   task automatic preamble();
      carrier = 1'b1;
      rx_n = 0;
      for (int i = 0; i < 7; i++) send_byte(8'h55);
      send_byte(8'hD5);
   endtask

   task automatic drop_carrier();
      @(negedge clk); carrier = 1'b0;
      @(negedge clk); #1;
   endtask

   // len payload bytes + 4 FCS bytes; flip: corrupt one payload bit; extra trailing bits
   task automatic send_frame(input int len, input bit flip, input int extra, input int disc_at);
      logic [31:0] f;
      for (int i = 0; i < len; i++) tx[i] = 8'((len * 7 + i * 13 + 5) & 8'hFF);
      f = fcs_of(len);
      for (int k = 0; k < 4; k++) tx[len + k] = f[8*k +: 8];
      if (flip) tx[0][len % 8] = ~tx[0][len % 8];
      preamble();
      for (int i = 0; i < len + 4; i++) begin
         if (i == disc_at) begin
            @(negedge clk); discard = 1'b1;
            @(negedge clk); discard = 1'b0;
         end
         send_byte(tx[i]);
         // R10: idle cycle with a toggling unqualified bit
         @(negedge clk); rx_bit = 1'b1;
      end
      for (int e = 0; e < extra; e++) send_bit(e[0]);
      drop_carrier();
   endtask

   task automatic verify(input string tag, input int e0, input bit eg, input bit ec,
                         input bit ea, input bit ed, input int nb);
      int mism = 0;
      chk(tag, "frame_end count", ends - e0, 1);
      chk(tag, "status {good,crc,align,disc}",
          {stat_good, stat_crc_err, stat_align_err, stat_discarded}, {eg, ec, ea, ed});
      chk(tag, "byte count", rx_n, nb);
      for (int i = 0; i < nb && i < rx_n; i++) if (rx[i] != tx[i]) mism++;
      chk(tag, "byte contents mismatches", mism, 0);
   endtask

   initial begin
      #(5.0 * 190000);
      if (!done) begin
         vec++; bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
         $finish;
      end
   end

   initial begin
      int e0;
      repeat (4) @(negedge clk);
      // R1 reset state
      chk("R1", "outputs in reset",
          {byte_valid, frame_end, stat_good, stat_crc_err, stat_align_err, stat_discarded}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1", "outputs after reset",
          {byte_valid, frame_end, stat_good, stat_crc_err, stat_align_err, stat_discarded}, 0);

      // R3 R5: good frames over a sweep of lengths
      for (int len = 1; len <= 20; len++) begin
         e0 = ends; send_frame(len, 1'b0, 0, -1);
         verify("R5 R3 good", e0, 1, 0, 0, 0, len + 4);
      end
      // R6: corrupted, ending on a boundary
      for (int len = 1; len <= 8; len++) begin
         e0 = ends; send_frame(len, 1'b1, 0, -1);
         verify("R6 crc error", e0, 0, 1, 0, 0, len + 4);
      end
      // R5: good CRC with 1..7 trailing bits stays good; partial byte dropped (R3)
      for (int x = 1; x <= 7; x++) begin
         e0 = ends; send_frame(6, 1'b0, x, -1);
         verify("R5 trailing bits", e0, 1, 0, 0, 0, 10);
      end
      // R7: bad CRC with trailing bits
      for (int x = 1; x <= 7; x++) begin
         e0 = ends; send_frame(5, 1'b1, x, -1);
         verify("R7 alignment", e0, 0, 1, 1, 0, 9);
      end
      // R8: discard after a few bytes
      for (int d = 0; d <= 4; d++) begin
         e0 = ends; send_frame(8, 1'b0, 0, d);
         verify("R8 discard", e0, 0, 0, 0, 1, d);
      end
      e0 = ends; send_frame(8, 1'b1, 0, 3);
      verify("R8 discard keeps crc flag", e0, 0, 1, 0, 1, 3);
      e0 = ends; send_frame(4, 1'b0, 0, -1);
      verify("R8 cleared at next mark", e0, 1, 0, 0, 0, 8);

      // R6: mark then immediate drop (no complete byte)
      e0 = ends; preamble(); drop_carrier();
      verify("R6 empty frame", e0, 0, 1, 0, 0, 0);

      // R2: carrier drop during preamble gives no frame_end; R9 status held
      e0 = ends; carrier = 1'b1; rx_n = 0;
      for (int i = 0; i < 12; i++) send_bit(i[0] ? 1'b0 : 1'b1);
      drop_carrier(); repeat (4) @(negedge clk);
      chk("R2", "no frame_end on aborted preamble", ends - e0, 0);
      chk("R9", "status held after abort",
          {stat_good, stat_crc_err, stat_align_err, stat_discarded}, 4'b0100);
      chk("R2", "no bytes from preamble", rx_n, 0);

      // R10: unqualified ones between preamble ones must not form a mark
      e0 = ends; carrier = 1'b1; rx_n = 0;
      for (int i = 0; i < 6; i++) begin
         send_bit(1'b1);
         @(negedge clk); rx_bit = 1'b1;
         send_bit(1'b0);
      end
      drop_carrier(); repeat (2) @(negedge clk);
      chk("R10", "no mark from unqualified ones", ends - e0, 0);

      // R4 R9: bad frame then good frame back to back
      e0 = ends; send_frame(7, 1'b1, 3, -1);
      verify("R4 first of pair", e0, 0, 1, 1, 0, 11);
      e0 = ends; send_frame(7, 1'b0, 0, -1);
      verify("R4 R9 second of pair", e0, 1, 0, 0, 0, 11);
      repeat (10) @(negedge clk);
      chk("R9", "status stable while idle",
          {stat_good, stat_crc_err, stat_align_err, stat_discarded}, 4'b1000);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end
endmodule